// File: doc/BRIEF.md
# Multi-Level Overcurrent Protection Sequencer

This block is the digital decision core of a discharge protector for a battery pack. It receives raw flags from analog comparators: three overcurrent thresholds in ascending order, an undervoltage flag and a load-release flag. Every flag passes through a two-flop synchronizer first. The block clocks at the slow timing rate, about 3.5 kHz, so one clock is one delay tick. Each fault condition has to persist for its own programmed number of ticks before the block acts on it.

The controller has three named states. `ST_NORM` is normal operation. `ST_OC` is a latched overcurrent fault. `ST_UV` is undervoltage lockout. The transitions are:
- NORM→OC when any enabled overcurrent level is qualified.
- NORM→UV when the undervoltage flag is qualified and no overcurrent level is qualified in the same cycle.
- OC→NORM when the release flag is seen.
- UV→NORM when the undervoltage flag is seen low.

Both fault states turn on the load-sense pulldown. The discharge output is a single "pull low" enable; when it is off, the pin is high-impedance. A polarity input selects whether a fault asserts or removes the pull-down.

Each delay is set as a power-of-two exponent. The delay is 2^e ticks, with e from 0 to 14, which spans about 0.28 ms to 4.6 s. The level-2 timer starts when the level-1 flag rises and fires once level 2 is also present. Level 3 can be switched off.

Top module: `ocp_seq`

## Requirements
- R1: After reset the state is ST_NORM. `load_pd_en` is 0 and `dsg_pull_low` equals `pol_high`.
- R2: A level-1 flag held continuously enters ST_OC at the 2^`dly1_exp`+2-th clock edge after it is applied (two synchronizer stages, then the delay). A shorter excursion leaves ST_NORM. Exponents up to 14 are honoured.
- R3: The level-2 timer counts while the level-1 or level-2 flag is present. If level 2 arrives after 2^`dly2_exp` ticks of level 1 have already passed, ST_OC is entered at the third edge after level 2 is applied.
- R4: With `lvl3_on`=1, a level-3 flag held for 2^`dly3_exp` ticks enters ST_OC.
- R5: With `lvl3_on`=0, a level-3 flag on its own never leaves ST_NORM.
- R6: A timer whose flag drops before terminal count restarts from zero. Two sub-delay excursions separated by one low cycle do not add up.
- R7: ST_OC is held while the release flag is low, even after every overcurrent flag has cleared. A release flag returns the state to ST_NORM at the third edge after it is applied.
- R8: The release flag has no effect in ST_NORM or ST_UV.
- R9: An undervoltage flag held for 2^`dlyuv_exp` ticks in ST_NORM enters ST_UV. The state returns to ST_NORM at the third edge after the flag drops.
- R10: ST_UV is never entered from ST_OC. Undervoltage present during ST_OC starts its delay only after release.
- R11: `load_pd_en` is 1 in ST_OC and ST_UV and 0 in ST_NORM.
- R12: `dsg_pull_low` = fault XOR `pol_high`. With `pol_high`=0, a fault pulls low and normal is high-impedance. With `pol_high`=1, normal pulls low and a fault is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timing clock, one delay tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc1_async | input | 1 | Level-1 overcurrent comparator flag (lowest threshold) |
| oc2_async | input | 1 | Level-2 overcurrent comparator flag |
| oc3_async | input | 1 | Level-3 overcurrent comparator flag (highest threshold) |
| uv_async | input | 1 | Supply at or below the lockout threshold |
| rel_async | input | 1 | Load-side release comparator flag |
| lvl3_on | input | 1 | 1 enables level-3 detection |
| pol_high | input | 1 | 0: fault pulls low; 1: normal pulls low |
| dly1_exp | input | 4 | Level-1 delay exponent, delay = 2^e ticks |
| dly2_exp | input | 4 | Level-2 delay exponent |
| dly3_exp | input | 4 | Level-3 delay exponent |
| dlyuv_exp | input | 4 | Undervoltage delay exponent |
| dsg_pull_low | output | 1 | 1 drives the discharge gate pin low, 0 leaves it high-impedance |
| load_pd_en | output | 1 | Enables the internal load-sense pulldown |

## Verification
The bench drives several input patterns and each one separates a different behaviour:
- A level-1 pulse shorter than its delay against a held one separates qualification from raw detection.
- Two sub-delay pulses split by one idle cycle expose a timer that accumulates instead of restarting.
- A level-1 flag held past the level-2 delay, with level 2 added late, shows whether the level-2 timer started at the level-1 crossing.
- A level-3 flag on its own, with level 3 disabled and then enabled, isolates the enable bit.
- Undervoltage held during a latched overcurrent, and release pulses in every state, distinguish the three exit paths and the lockout entry restriction.
- Both polarities and the longest delay exponent are exercised.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    localparam int N_FLAGS = 5;
    localparam int FI_OC1  = 0;
    localparam int FI_OC2  = 1;
    localparam int FI_OC3  = 2;
    localparam int FI_UV   = 3;
    localparam int FI_REL  = 4;

    typedef enum logic [1:0] {
        ST_NORM = 2'd0,
        ST_OC   = 2'd1,
        ST_UV   = 2'd2
    } prot_state_t;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta, stab;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= 1'b0;
                stab <= 1'b0;
            end else begin
                meta <= d_async[i];
                stab <= meta;
            end
        end
        assign q_sync[i] = stab;
    end
endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
    parameter int MAX_EXP = 14,
    localparam int EXP_W  = $clog2(MAX_EXP + 1),
    localparam int CNT_W  = MAX_EXP + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             fire,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             done
);
    logic [EXP_W-1:0] exp_eff;
    logic [CNT_W-1:0] span, last, cnt;
    logic             reached;

    always_comb begin
        exp_eff = (exp_sel > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_sel;
        span    = CNT_W'(1) << exp_eff;
        last    = span - CNT_W'(1);
        reached = (cnt == last);
        done    = arm & fire & reached;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!arm)     cnt <= '0;
        else if (!reached) cnt <= cnt + CNT_W'(1);
    end

    // R6: a dropped condition leaves the count at zero
    a_r6_timer_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cnt == '0));
    // R2: the count never runs past its terminal value
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= last) || !$stable(exp_sel));
endmodule

// File: rtl/ocp_seq.sv
module ocp_seq
    import ocp_pkg::*;
#(
    parameter int MAX_EXP = 14,
    localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oc1_async,
    input  logic             oc2_async,
    input  logic             oc3_async,
    input  logic             uv_async,
    input  logic             rel_async,
    input  logic             lvl3_on,
    input  logic             pol_high,
    input  logic [EXP_W-1:0] dly1_exp,
    input  logic [EXP_W-1:0] dly2_exp,
    input  logic [EXP_W-1:0] dly3_exp,
    input  logic [EXP_W-1:0] dlyuv_exp,
    output logic             dsg_pull_low,
    output logic             load_pd_en
);
    logic [N_FLAGS-1:0] raw_flags, syn;
    prot_state_t        state, nxt;
    logic               in_norm, fault;
    logic               q1, q2, q3, quv;

    assign raw_flags[FI_OC1] = oc1_async;
    assign raw_flags[FI_OC2] = oc2_async;
    assign raw_flags[FI_OC3] = oc3_async;
    assign raw_flags[FI_UV]  = uv_async;
    assign raw_flags[FI_REL] = rel_async;

    sync_bank #(.WIDTH(N_FLAGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_flags), .q_sync(syn)
    );

    assign in_norm = (state == ST_NORM);

    qual_timer #(.MAX_EXP(MAX_EXP)) u_t1 (
        .clk(clk), .rst_n(rst_n), .arm(in_norm & syn[FI_OC1]),
        .fire(1'b1), .exp_sel(dly1_exp), .done(q1)
    );
    // level-2 delay runs from the level-1 crossing
    qual_timer #(.MAX_EXP(MAX_EXP)) u_t2 (
        .clk(clk), .rst_n(rst_n), .arm(in_norm & (syn[FI_OC1] | syn[FI_OC2])),
        .fire(syn[FI_OC2]), .exp_sel(dly2_exp), .done(q2)
    );
    qual_timer #(.MAX_EXP(MAX_EXP)) u_t3 (
        .clk(clk), .rst_n(rst_n), .arm(in_norm & lvl3_on & syn[FI_OC3]),
        .fire(1'b1), .exp_sel(dly3_exp), .done(q3)
    );
    qual_timer #(.MAX_EXP(MAX_EXP)) u_tuv (
        .clk(clk), .rst_n(rst_n), .arm(in_norm & syn[FI_UV]),
        .fire(1'b1), .exp_sel(dlyuv_exp), .done(quv)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORM;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORM: begin
                if (q1 | q2 | q3) nxt = ST_OC;
                else if (quv)     nxt = ST_UV;
            end
            ST_OC:   if (syn[FI_REL]) nxt = ST_NORM;
            ST_UV:   if (!syn[FI_UV]) nxt = ST_NORM;
            default: nxt = ST_NORM;
        endcase
    end

    // outputs
    always_comb begin
        fault        = (state != ST_NORM);
        load_pd_en   = fault;
        dsg_pull_low = fault ^ pol_high;
    end

    a_r7_oc_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OC && !syn[FI_REL]) |=> (state == ST_OC));
    a_r10_no_uv_from_oc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OC) |=> (state != ST_UV));
    a_r9_uv_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UV && !syn[FI_UV]) |=> (state == ST_NORM));
    a_r2_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORM && !syn[FI_OC1] && !syn[FI_OC2] && !syn[FI_OC3])
        |=> (state != ST_OC));
    a_r5_lvl3_off: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl3_on |-> !q3);
endmodule

// File: tb/sim_ocp_seq.sv
module sim_ocp_seq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic oc1 = 0, oc2 = 0, oc3 = 0, uv = 0, rel = 0, l3 = 0, pol = 0;
    logic [3:0] e1 = 4'd3, e2 = 4'd2, e3 = 4'd0, eu = 4'd4;
    logic pull_low, pd_en;
    int checks = 0, errors = 0, cyc = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ocp_seq u0 (
        .clk(clk), .rst_n(rst_n), .oc1_async(oc1), .oc2_async(oc2),
        .oc3_async(oc3), .uv_async(uv), .rel_async(rel), .lvl3_on(l3),
        .pol_high(pol), .dly1_exp(e1), .dly2_exp(e2), .dly3_exp(e3),
        .dlyuv_exp(eu), .dsg_pull_low(pull_low), .load_pd_en(pd_en)
    );

    // behavioural reference: 0 normal, 1 overcurrent, 2 lockout
    int st = 0, h1 = 0, h2 = 0, h3 = 0, hu = 0;
    bit s1[5], s2[5];

    function automatic int ticks(input logic [3:0] e);
        return 1 << ((e > 14) ? 14 : e);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit nrm, d1, d2, d3, du;
        cyc++;
        if (!rst_n) begin
            st = 0; h1 = 0; h2 = 0; h3 = 0; hu = 0;
            foreach (s1[i]) begin s1[i] = 0; s2[i] = 0; end
        end else begin
            nrm = (st == 0);
            h1 = (nrm && s2[0]) ? h1 + 1 : 0;
            h2 = (nrm && (s2[0] || s2[1])) ? h2 + 1 : 0;
            h3 = (nrm && l3 && s2[2]) ? h3 + 1 : 0;
            hu = (nrm && s2[3]) ? hu + 1 : 0;
            d1 = h1 >= ticks(e1);
            d2 = s2[1] && (h2 >= ticks(e2));
            d3 = h3 >= ticks(e3);
            du = hu >= ticks(eu);
            case (st)
                0: if (d1 || d2 || d3) st = 1; else if (du) st = 2;
                1: if (s2[4]) st = 0;
                default: if (!s2[3]) st = 0;
            endcase
            foreach (s2[i]) s2[i] = s1[i];
            s1[0] = oc1; s1[1] = oc2; s1[2] = oc3; s1[3] = uv; s1[4] = rel;
        end
        #1;
        chk({cur_req, " model pull_low"}, int'(pull_low), int'((st != 0) ^ pol));
        chk({cur_req, " model R11 pd_en"}, int'(pd_en), int'(st != 0));
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wn(input int m);
        repeat (m) @(negedge clk);
    endtask

    task automatic release_oc();
        rel = 1; wn(1); rel = 0; wn(4);
    endtask

    initial begin
        wn(2); rst_n = 1; wn(1);
        cur_req = "R1";
        chk("R1 pull_low", int'(pull_low), 0);
        chk("R1 pd_en", int'(pd_en), 0);

        cur_req = "R2";                 // T1 = 8
        oc1 = 1; wn(6); oc1 = 0; wn(12);
        chk("R2 short excursion", int'(pd_en), 0);
        oc1 = 1; wn(9);
        chk("R2 before delay", int'(pd_en), 0);
        wn(1);
        chk("R2 fault at delay", int'(pd_en), 1);
        chk("R11 pd_en in OC", int'(pd_en), 1);

        cur_req = "R7";
        oc1 = 0; wn(12);
        chk("R7 held after flags clear", int'(pull_low), 1);
        rel = 1; wn(2);
        chk("R7 not yet released", int'(pd_en), 1);
        wn(1); rel = 0;
        chk("R7 released", int'(pd_en), 0);
        wn(3);

        cur_req = "R6";
        oc1 = 1; wn(6); oc1 = 0; wn(1); oc1 = 1; wn(6); oc1 = 0; wn(10);
        chk("R6 excursions do not add", int'(pd_en), 0);

        cur_req = "R3";                 // T2 = 4, level 1 held 6 ticks first
        oc1 = 1; wn(6); oc2 = 1; wn(2);
        chk("R3 not before sync", int'(pd_en), 0);
        wn(1);
        chk("R3 fault within level-2 window", int'(pd_en), 1);
        oc1 = 0; oc2 = 0; release_oc();
        chk("R3 released", int'(pd_en), 0);

        cur_req = "R5";
        l3 = 0; oc3 = 1; wn(30);
        chk("R5 level3 disabled", int'(pd_en), 0);
        oc3 = 0; wn(3);

        cur_req = "R4";                 // T3 = 1
        l3 = 1; oc3 = 1; wn(2);
        chk("R4 not before sync", int'(pd_en), 0);
        wn(1);
        chk("R4 level3 fault", int'(pd_en), 1);
        oc3 = 0; release_oc();

        cur_req = "R8";
        rel = 1; wn(8); rel = 0; wn(3);
        chk("R8 release in normal", int'(pd_en), 0);

        cur_req = "R9";                 // Tu = 16
        uv = 1; wn(17);
        chk("R9 before delay", int'(pd_en), 0);
        wn(1);
        chk("R9 lockout entered", int'(pd_en), 1);
        cur_req = "R8";
        rel = 1; wn(5); rel = 0; wn(3);
        chk("R8 release in lockout", int'(pd_en), 1);
        cur_req = "R9";
        uv = 0; wn(2);
        chk("R9 still locked", int'(pd_en), 1);
        wn(1);
        chk("R9 lockout left", int'(pd_en), 0);
        wn(3);

        cur_req = "R10";
        oc1 = 1; wn(12); oc1 = 0;
        uv = 1; wn(40);
        chk("R10 held in OC with uv", int'(pd_en), 1);
        rel = 1; wn(1); rel = 0; wn(2);
        chk("R10 release despite uv", int'(pd_en), 0);
        wn(20);
        chk("R10 lockout after release", int'(pd_en), 1);
        uv = 0; wn(5);

        cur_req = "R12";
        pol = 1; wn(1);
        chk("R12 high pol normal", int'(pull_low), 1);
        oc1 = 1; wn(12); oc1 = 0;
        chk("R12 high pol fault", int'(pull_low), 0);
        release_oc();
        chk("R12 high pol back", int'(pull_low), 1);
        pol = 0; wn(2);

        cur_req = "R2";                 // longest delay 16384
        e1 = 4'd14; wn(1);
        oc1 = 1; wn(16385);
        chk("R2 long delay not yet", int'(pd_en), 0);
        wn(1);
        chk("R2 long delay fault", int'(pd_en), 1);
        oc1 = 0; release_oc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule